// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller decides what a small processor core does after it issues a sleep request, and how the core returns to normal operation. A single select bit picks between two depths. In light sleep only the CPU clock is gated. In deep standby the CPU clock, the peripheral clocks and the oscillator are all switched off. Waking from deep standby first turns the oscillator back on. The controller then counts a programmable settling interval before it releases the clocks and signals that interrupt handling may start.

Two active-low pins override the sleep logic. The reset pin forces the reset state from any mode, and releasing it starts reset handling. The hardware-standby pin parks the block in a fully powered-down state that only a reset can end. Both pins pass through a two-stage synchroniser before the sequencer uses them. Reset outranks hardware standby, and hardware standby outranks every interrupt wake. Interrupt prioritisation, the oscillator itself and the core are outside this block.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: In run mode, a sleep request with the standby-select bit at 0 moves the block to light sleep on the next clock. In light sleep the CPU clock enable is 0, and the peripheral clock enable and oscillator enable are 1.
- R2: In run mode, a sleep request with the standby-select bit at 1 moves the block to deep standby on the next clock. In deep standby the CPU clock enable, the peripheral clock enable and the oscillator enable are all 0.
- R3: In light sleep, a qualified wake source returns the block to run on the next clock and raises the interrupt-start strobe in that cycle. NMI is qualified even while the CPU mask flag is set.
- R4: External line k (bit k of the eight-bit interrupt bus) counts only when bit k of the enable bus is also 1. The extra wake source counts only with its own enable bit. While the CPU mask flag is 1, neither of these wakes the block from either sleep depth, and the mode stays unchanged.
- R5: In deep standby, a qualified wake source (NMI, an enabled external line, or the enabled extra source) moves the block to oscillator settling. In settling the oscillator enable is 1 and both clock enables are 0. Deep standby is never left directly for run or light sleep.
- R6: Settling lasts exactly 2^(8+2·code) clock cycles, where code is the 3-bit settling field as sampled on the wake cycle. Later changes to the field have no effect. The block then enters run and raises the interrupt-start strobe.
- R7: A low reset pin reaches the sequencer three clocks after it is driven, and the block enters the reset state. Three clocks after the pin goes high, the block enters run and raises the reset-start strobe. The same sequence follows release of the block reset.
- R8: A low hardware-standby pin moves the block to hardware standby (all three enables 0) from run, either sleep depth or settling. When it arrives in the same cycle as an interrupt wake, it wins. Once in hardware standby, the block stays there regardless of interrupts or release of the pin, until the reset pin is asserted.
- R9: With both pins low, reset wins. If the reset pin is released while the hardware-standby pin is still low, the block goes to hardware standby and raises no reset-start strobe.
- R10: Each strobe is high for exactly one cycle, and the two strobes are never high together.
- R11: The mode code reads 0 run, 1 light sleep, 2 deep standby, 3 settling, 4 hardware standby and 5 reset. Run drives all three enables to 1. Reset drives only the oscillator enable to 1. After the block reset the mode is 5 with both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sleep_req_i | input | 1 | Sleep request strobe from the core |
| stby_sel_i | input | 1 | 0 selects light sleep, 1 selects deep standby |
| settle_sel_i | input | 3 | Oscillator settling-time code |
| nmi_i | input | 1 | Non-maskable interrupt request |
| ext_irq_i | input | 8 | External interrupt request lines |
| ext_irq_en_i | input | 8 | Per-line enables for the external lines |
| aux_irq_i | input | 1 | Extra wake-source interrupt request |
| aux_irq_en_i | input | 1 | Enable for the extra wake source |
| cpu_mask_i | input | 1 | CPU-side mask for all non-NMI interrupts |
| reset_pin_n_i | input | 1 | Asynchronous active-low reset pin |
| hwstby_pin_n_i | input | 1 | Asynchronous active-low hardware-standby pin |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| irq_start_o | output | 1 | One-cycle strobe: begin interrupt handling |
| rst_start_o | output | 1 | One-cycle strobe: begin reset handling |
| mode_o | output | 3 | Current mode code |

## Verification
The wake logic is exercised with NMI, with a single enabled external line, and with the extra source. Each is tried with the CPU mask set and cleared and with its enable on and off, which separates the mask gate from the per-line enable gate. Settling is run with codes 0 and 1, and the code is changed after the wake. This distinguishes a length sampled at wake from one that tracks the live field, and the checks on the last settling cycle and the first run cycle catch off-by-one errors. The pin tests assert the hardware-standby pin alone, together with a wake in the same cycle, and together with reset. This covers both priority orders and the stickiness of hardware standby.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power sequencer: mode encoding and the clock
// enable bundle each mode drives. Assumes a 3-bit mode code.
package lpm_pkg;

    typedef enum logic [2:0] {
        MODE_RUN    = 3'd0,
        MODE_LIGHT  = 3'd1,
        MODE_DEEP   = 3'd2,
        MODE_SETTLE = 3'd3,
        MODE_HWSTBY = 3'd4,
        MODE_RESET  = 3'd5
    } lpm_mode_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } lpm_clk_en_t;

    // Map a mode to the enables it drives.
    function automatic lpm_clk_en_t clk_en_for(lpm_mode_e m);
        lpm_clk_en_t e;
        case (m)
            MODE_RUN:    e = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
            MODE_LIGHT:  e = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
            MODE_SETTLE: e = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
            MODE_RESET:  e = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
            default:     e = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/lpm_pin_sync.sv
// Multi-stage synchroniser for asynchronous active-low pins.
// Assumes: every stage resets to 0, so after block reset each pin
// reads as asserted until its real level has propagated.
module lpm_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // First stage captures the raw pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pin_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-registers the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/lpm_wake_eval.sv
// Wake qualification shared by both sleep depths.
// NMI always qualifies. An external line needs its enable bit, the
// extra source needs its own enable, and the CPU mask blocks both.
// Purely combinational. Assumes inputs are already synchronous.
module lpm_wake_eval #(
    parameter int N_EXT = 8
) (
    input  logic             nmi_i,
    input  logic             cpu_mask_i,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic [N_EXT-1:0] ext_en_i,
    input  logic             aux_irq_i,
    input  logic             aux_en_i,
    output logic             wake_o
);

    logic [N_EXT-1:0] line_hit;
    logic             maskable_hit;

    for (genvar k = 0; k < N_EXT; k++) begin : g_line
        assign line_hit[k] = ext_irq_i[k] & ext_en_i[k];
    end

    // Combine maskable sources, then apply the CPU mask; NMI bypasses it.
    always_comb begin
        maskable_hit = (|line_hit) | (aux_irq_i & aux_en_i);
        wake_o       = nmi_i | (maskable_hit & ~cpu_mask_i);
    end

endmodule

// File: rtl/lpm_settle_timer.sv
// Oscillator settling down-counter. load_i captures the settling code
// and loads 2^(BASE_LOG+STEP_LOG*code)-1. While count_i is high the
// counter falls toward zero. done_o is high while it holds zero.
// Assumes load_i and count_i are never high together.
module lpm_settle_timer #(
    parameter int SEL_W    = 3,
    parameter int BASE_LOG = 8,
    parameter int STEP_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             count_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             done_o
);

    localparam int MAX_CODE = (1 << SEL_W) - 1;
    localparam int CNT_W    = BASE_LOG + STEP_LOG * MAX_CODE;

    logic [CNT_W-1:0] cnt_q;

    // Number of cycles minus one for a given code.
    function automatic logic [CNT_W-1:0] load_val(logic [SEL_W-1:0] code);
        int          sh;
        logic [CNT_W:0] full;
        sh   = BASE_LOG + STEP_LOG * int'(code);
        full = ((CNT_W+1)'(1) << sh) - (CNT_W+1)'(1);
        return full[CNT_W-1:0];
    endfunction

    // Load on wake, then count down while settling.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (load_i)                   cnt_q <= load_val(sel_i);
        else if (count_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/lpm_seq_ctrl.sv
// Low-power mode sequencer top. Synchronises the reset and standby
// pins, qualifies wake sources and runs the mode state machine that
// drives the clock enables and the handling-start strobes.
// Priority: reset pin, then hardware-standby pin, then wakes.
// Assumes sleep_req_i and the interrupt inputs are synchronous to clk.
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int N_EXT       = 8,
    parameter int SEL_W       = 3,
    parameter int SETTLE_BASE = 8,
    parameter int SETTLE_STEP = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req_i,
    input  logic             stby_sel_i,
    input  logic [SEL_W-1:0] settle_sel_i,
    input  logic             nmi_i,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic [N_EXT-1:0] ext_irq_en_i,
    input  logic             aux_irq_i,
    input  logic             aux_irq_en_i,
    input  logic             cpu_mask_i,
    input  logic             reset_pin_n_i,
    input  logic             hwstby_pin_n_i,
    output logic             cpu_clk_en_o,
    output logic             per_clk_en_o,
    output logic             osc_en_o,
    output logic             irq_start_o,
    output logic             rst_start_o,
    output logic [2:0]       mode_o
);

    localparam int PIN_RST = 0;
    localparam int PIN_HWS = 1;

    logic [1:0]  pins_s;
    logic        wake;
    logic        settle_done;
    logic        settle_load;
    logic        irq_nxt;
    logic        rst_nxt;
    lpm_mode_e   mode_q;
    lpm_mode_e   mode_nxt;
    lpm_clk_en_t en;

    lpm_pin_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_pin_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({hwstby_pin_n_i, reset_pin_n_i}),
        .sync_o (pins_s)
    );

    lpm_wake_eval #(
        .N_EXT (N_EXT)
    ) u_wake_eval (
        .nmi_i      (nmi_i),
        .cpu_mask_i (cpu_mask_i),
        .ext_irq_i  (ext_irq_i),
        .ext_en_i   (ext_irq_en_i),
        .aux_irq_i  (aux_irq_i),
        .aux_en_i   (aux_irq_en_i),
        .wake_o     (wake)
    );

    lpm_settle_timer #(
        .SEL_W    (SEL_W),
        .BASE_LOG (SETTLE_BASE),
        .STEP_LOG (SETTLE_STEP)
    ) u_settle_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (settle_load),
        .count_i (mode_q == MODE_SETTLE),
        .sel_i   (settle_sel_i),
        .done_o  (settle_done)
    );

    // Next-mode selection with pin priority ahead of every wake.
    always_comb begin
        mode_nxt    = mode_q;
        irq_nxt     = 1'b0;
        rst_nxt     = 1'b0;
        settle_load = 1'b0;
        if (!pins_s[PIN_RST]) begin
            mode_nxt = MODE_RESET;
        end else if (!pins_s[PIN_HWS]) begin
            mode_nxt = MODE_HWSTBY;
        end else begin
            case (mode_q)
                MODE_RUN: begin
                    if (sleep_req_i) mode_nxt = stby_sel_i ? MODE_DEEP : MODE_LIGHT;
                end
                MODE_LIGHT: begin
                    if (wake) begin
                        mode_nxt = MODE_RUN;
                        irq_nxt  = 1'b1;
                    end
                end
                MODE_DEEP: begin
                    if (wake) begin
                        mode_nxt    = MODE_SETTLE;
                        settle_load = 1'b1;
                    end
                end
                MODE_SETTLE: begin
                    if (settle_done) begin
                        mode_nxt = MODE_RUN;
                        irq_nxt  = 1'b1;
                    end
                end
                MODE_RESET: begin
                    mode_nxt = MODE_RUN;
                    rst_nxt  = 1'b1;
                end
                default: mode_nxt = mode_q;
            endcase
        end
    end

    // Mode register and one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_RESET;
            irq_start_o <= 1'b0;
            rst_start_o <= 1'b0;
        end else begin
            mode_q      <= mode_nxt;
            irq_start_o <= irq_nxt;
            rst_start_o <= rst_nxt;
        end
    end

    // Decode the enables from the current mode.
    always_comb begin
        en           = clk_en_for(mode_q);
        cpu_clk_en_o = en.cpu;
        per_clk_en_o = en.per;
        osc_en_o     = en.osc;
        mode_o       = mode_q;
    end

endmodule

// File: rtl/lpm_seq_ctrl_chk.sv
// Checker for lpm_seq_ctrl, attached via bind. Observes only the
// top-level outputs. Assumes mode codes 0..5 as in lpm_pkg.
module lpm_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_clk_en_o,
    input logic       per_clk_en_o,
    input logic       osc_en_o,
    input logic       irq_start_o,
    input logic       rst_start_o,
    input logic [2:0] mode_o
);

    p_light_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd1 |-> (!cpu_clk_en_o && per_clk_en_o && osc_en_o));

    p_deep_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd2 |-> (!cpu_clk_en_o && !per_clk_en_o && !osc_en_o));

    p_irq_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start_o |-> (mode_o == 3'd0 && ($past(mode_o) == 3'd1 || $past(mode_o) == 3'd3)));

    p_settle_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd3 |-> (osc_en_o && !cpu_clk_en_o && !per_clk_en_o));

    p_deep_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd2 |=> (mode_o != 3'd0 && mode_o != 3'd1));

    p_rst_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_start_o |-> (mode_o == 3'd0 && $past(mode_o) == 3'd5));

    p_hws_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 3'd4 |=> (mode_o == 3'd4 || mode_o == 3'd5));

    p_irq_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start_o |=> !irq_start_o);

    p_rst_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_start_o |=> !rst_start_o);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_start_o && rst_start_o));

    p_mode_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd5);

endmodule

bind lpm_seq_ctrl lpm_seq_ctrl_chk u_chk (.*);

// File: tb/lpm_seq_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_seq_ctrl_bench;

    typedef struct {
        int    due;
        int    mode;
        bit    irq;
        bit    rst;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sleep_req, stby_sel, nmi, aux_irq, aux_en, cpu_mask;
    logic       reset_pin_n, hwstby_pin_n;
    logic [2:0] settle_sel;
    logic [7:0] ext_irq, ext_en;
    logic       cpu_en, per_en, osc_en, irq_start, rst_start;
    logic [2:0] mode;

    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   fin = 1'b0;
    exp_t q[$];

    lpm_seq_ctrl u_lpm_seq_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .sleep_req_i    (sleep_req),
        .stby_sel_i     (stby_sel),
        .settle_sel_i   (settle_sel),
        .nmi_i          (nmi),
        .ext_irq_i      (ext_irq),
        .ext_irq_en_i   (ext_en),
        .aux_irq_i      (aux_irq),
        .aux_irq_en_i   (aux_en),
        .cpu_mask_i     (cpu_mask),
        .reset_pin_n_i  (reset_pin_n),
        .hwstby_pin_n_i (hwstby_pin_n),
        .cpu_clk_en_o   (cpu_en),
        .per_clk_en_o   (per_en),
        .osc_en_o       (osc_en),
        .irq_start_o    (irq_start),
        .rst_start_o    (rst_start),
        .mode_o         (mode)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected {cpu, per, osc} enables per mode, from R1, R2, R5, R8, R11.
    function automatic logic [2:0] exp_en(int m);
        case (m)
            0:       return 3'b111;
            1:       return 3'b011;
            3:       return 3'b001;
            5:       return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue an expectation for the current cycle.
    task automatic expect_st(string tag, int m, bit irq, bit rst);
        exp_t e;
        e.due = cyc; e.mode = m; e.irq = irq; e.rst = rst; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pop due expectations and compare against the outputs.
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                it = q.pop_front();
                n_vec++;
                if (int'(mode) != it.mode || {cpu_en, per_en, osc_en} != exp_en(it.mode) ||
                    irq_start != it.irq || rst_start != it.rst) begin
                    n_bad++;
                    $display("FAIL %s: got mode=%0d en=%b irq=%b rst=%b, expected mode=%0d en=%b irq=%b rst=%b",
                             it.tag, mode, {cpu_en, per_en, osc_en}, irq_start, rst_start,
                             it.mode, exp_en(it.mode), it.irq, it.rst);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog: got still running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reset_pin_n = 1'b1; hwstby_pin_n = 1'b1;
        sleep_req = 0; stby_sel = 0; settle_sel = 3'd0; nmi = 0;
        ext_irq = 8'h00; ext_en = 8'h00; aux_irq = 0; aux_en = 0; cpu_mask = 0;
        tick(3);
        expect_st("R11 reset state", 5, 0, 0);
        rst_n = 1'b1;
        tick(1); expect_st("R7 sync stage 1", 5, 0, 0);
        tick(1); expect_st("R7 sync stage 2", 5, 0, 0);
        tick(1); expect_st("R7 reset handling start", 0, 0, 1);
        tick(1); expect_st("R10 reset strobe single", 0, 0, 0);

        // Light sleep entry and masking.
        sleep_req = 1; stby_sel = 0;
        tick(1); sleep_req = 0;
        expect_st("R1 light sleep entry", 1, 0, 0);
        cpu_mask = 1; ext_irq = 8'h08; ext_en = 8'h08; aux_irq = 1; aux_en = 1;
        tick(2); expect_st("R4 masked sources in light sleep", 1, 0, 0);
        cpu_mask = 0; ext_en = 8'h00; aux_en = 0;
        tick(2); expect_st("R4 disabled sources in light sleep", 1, 0, 0);
        ext_en = 8'h08;
        tick(1); expect_st("R3 enabled line wakes light sleep", 0, 1, 0);
        ext_irq = 8'h00; ext_en = 8'h00; aux_irq = 0;
        tick(1); expect_st("R10 irq strobe single", 0, 0, 0);

        // NMI through the mask.
        sleep_req = 1;
        tick(1); sleep_req = 0;
        expect_st("R1 light sleep again", 1, 0, 0);
        cpu_mask = 1; nmi = 1;
        tick(1); expect_st("R3 NMI wakes while masked", 0, 1, 0);
        nmi = 0; cpu_mask = 0;
        tick(1); expect_st("R10 irq strobe drop", 0, 0, 0);

        // Deep standby, code 0, extra source wake.
        stby_sel = 1; sleep_req = 1;
        tick(1); sleep_req = 0;
        expect_st("R2 deep standby entry", 2, 0, 0);
        cpu_mask = 1; ext_irq = 8'h80; ext_en = 8'h80;
        tick(2); expect_st("R4 masked line in deep standby", 2, 0, 0);
        cpu_mask = 0; ext_en = 8'h7F;
        tick(2); expect_st("R4 disabled line in deep standby", 2, 0, 0);
        aux_irq = 1; aux_en = 0;
        tick(1); expect_st("R4 extra source without enable", 2, 0, 0);
        aux_en = 1; ext_irq = 8'h00; settle_sel = 3'd0;
        tick(1); expect_st("R5 extra source starts settling", 3, 0, 0);
        aux_irq = 0; aux_en = 0; ext_en = 8'h00;
        tick(255); expect_st("R6 last settle cycle code 0", 3, 0, 0);
        tick(1); expect_st("R6 run after 256 cycles", 0, 1, 0);
        tick(1); expect_st("R10 irq strobe after settle", 0, 0, 0);

        // Deep standby, code 1 captured at wake, external line wake.
        sleep_req = 1;
        tick(1); sleep_req = 0;
        expect_st("R2 deep standby second entry", 2, 0, 0);
        settle_sel = 3'd1; ext_irq = 8'h01; ext_en = 8'h01;
        tick(1); expect_st("R5 enabled line starts settling", 3, 0, 0);
        ext_irq = 8'h00; ext_en = 8'h00; settle_sel = 3'd0;
        tick(1023); expect_st("R6 last settle cycle code 1", 3, 0, 0);
        tick(1); expect_st("R6 run after 1024 cycles", 0, 1, 0);

        // Hardware standby during settling, stickiness.
        sleep_req = 1;
        tick(1); sleep_req = 0;
        expect_st("R2 deep standby third entry", 2, 0, 0);
        nmi = 1;
        tick(1); nmi = 0;
        expect_st("R5 NMI starts settling", 3, 0, 0);
        hwstby_pin_n = 0;
        tick(2); expect_st("R8 standby pin in sync", 3, 0, 0);
        tick(1); expect_st("R8 standby from settling", 4, 0, 0);
        hwstby_pin_n = 1; nmi = 1;
        tick(4); expect_st("R8 standby held after pin release", 4, 0, 0);
        nmi = 0;
        reset_pin_n = 0;
        tick(2); expect_st("R7 reset pin in sync", 4, 0, 0);
        tick(1); expect_st("R7 reset leaves standby", 5, 0, 0);
        reset_pin_n = 1;
        tick(2); expect_st("R7 release in sync", 5, 0, 0);
        tick(1); expect_st("R7 reset handling after standby", 0, 0, 1);
        tick(1); expect_st("R10 reset strobe drop", 0, 0, 0);

        // Standby pin against a same-cycle wake from light sleep.
        stby_sel = 0; sleep_req = 1;
        tick(1); sleep_req = 0;
        expect_st("R1 light sleep third entry", 1, 0, 0);
        hwstby_pin_n = 0;
        tick(2); expect_st("R8 light sleep before pin arrives", 1, 0, 0);
        nmi = 1;
        tick(1); expect_st("R8 standby beats NMI", 4, 0, 0);
        nmi = 0;

        // Reset against standby.
        reset_pin_n = 0;
        tick(3); expect_st("R9 reset over standby", 5, 0, 0);
        reset_pin_n = 1;
        tick(3); expect_st("R9 release into standby, no strobe", 4, 0, 0);
        reset_pin_n = 0;
        tick(3); expect_st("R9 reset again", 5, 0, 0);
        reset_pin_n = 1; hwstby_pin_n = 1;
        tick(3); expect_st("R7 run after both released", 0, 0, 1);
        reset_pin_n = 0; hwstby_pin_n = 0;
        tick(3); expect_st("R9 both pins low from run", 5, 0, 0);
        reset_pin_n = 1; hwstby_pin_n = 1;
        tick(2); expect_st("R9 release in sync", 5, 0, 0);
        tick(1); expect_st("R7 run after both released again", 0, 0, 1);

        tick(2);
        if (q.size() > 0) begin
            n_bad += q.size();
            $display("FAIL all: got %0d unchecked expectations, expected 0", q.size());
        end
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule